// File: doc/BRIEF.md
# Microcode Next-Address Sequencer with Return Stack

This block picks the next microinstruction fetch address in a pipelined microcoded processor that has one delay slot. On every clock it looks at the decoded transfer fields of the instruction now executing: the kind of transfer, the jump condition result, the three control bits R, P and N, a flag asking for a return after the next instruction, and a target address. It then updates the fetch address. It also drives a 32-entry subroutine return stack.

One three-bit code covers plain jump, call and return for both jumps and dispatches. The N bit chooses whether the instruction already fetched into the delay slot runs or is turned into a no-op. A return can be requested one instruction early. That deferred return yields to any transfer the following instruction makes on its own. Each popped word carries a flag bit. When that bit is set, a location-counter advance strobe fires. A conditional jump coded R=1, P=1 raises an instruction-memory write request in place of a transfer.

A small state machine tracks the delay slot. Its states are ST_RUN (nothing outstanding), ST_KILL (the instruction executing now is squashed), ST_PEND (a deferred return applies at the end of this cycle) and ST_KILL_PEND (both). At every edge the next state is chosen from two conditions. The first is whether a squash is requested, which leads to ST_KILL or ST_KILL_PEND. The second is whether a deferred return is armed, which leads to ST_PEND or ST_KILL_PEND. When neither holds, the machine returns to ST_RUN.

Top module: `useq_nextaddr`

## Requirements
- R1: Synchronous reset sets fetch_pc to 0, the stack pointer to 0 and all stack words to 0, and clears the state to ST_RUN. While in reset, slot_nop, lc_advance and imem_wr_req are all 0.
- R2: An instruction is treated as sequential in three cases: xfer_kind is 2'b00 or 2'b11, or xfer_kind is 2'b01 (jump) and cond_met is 0. A sequential instruction advances fetch_pc by one (modulo 2^14), leaves the stack alone and squashes nothing.
- R3: A taken transfer is either a dispatch (xfer_kind 2'b10) or a jump whose condition is met. For a taken transfer with R=0 and P=0, the next fetch_pc is target_addr and the stack is not touched.
- R4: A taken transfer with R=0 and P=1 is a call. It pushes a word that holds ret_flag at bit 14 and a return address in bits 13:0. The return address is fetch_pc+1 when N=0, which is the address after the delay slot. It is fetch_pc when N=1, so the squashed slot instruction runs again on return. The next fetch_pc is target_addr.
- R5: A taken transfer with R=1 and P=0 pops, and bits 13:0 of the popped word become the next fetch_pc. A dispatch with R=1 and P=1 also pops, and its target_addr is ignored.
- R6: A met jump with R=1 and P=1 makes no transfer. It raises imem_wr_req for exactly the following cycle, advances fetch_pc by one, leaves the stack alone and squashes nothing.
- R7: A taken transfer with N=1 sets slot_nop for the next cycle. During that cycle every control input of the executing instruction is ignored, popj_next included.
- R8: A push first increments the 5-bit pointer and then writes the new slot. A pop reads the slot the pointer addresses and then decrements the pointer. The pointer wraps modulo 32.
- R9: When popj_next is set on an instruction that is not squashed, a deferred return is armed. At the end of the next instruction the block pops and jumps to the popped address, unless that next instruction makes a taken transfer. A squashed next instruction still lets the return happen.
- R10: If the instruction that follows an armed return makes a taken transfer of its own, the deferred return is dropped and that transfer alone decides the next fetch_pc and the stack action.
- R11: When a pop reads a word with bit 14 set, lc_advance goes high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| xfer_kind | input | 2 | 00 sequential, 01 jump, 10 dispatch, 11 treated as sequential |
| cond_met | input | 1 | Jump condition result |
| r_bit | input | 1 | Return bit of the transfer code |
| p_bit | input | 1 | Push (call) bit of the transfer code |
| n_bit | input | 1 | Squash-delay-slot bit |
| popj_next | input | 1 | Request a return after the next instruction |
| target_addr | input | 14 | Jump target or dispatch address |
| ret_flag | input | 1 | Flag stored at bit 14 of a pushed word |
| fetch_pc | output | 14 | Address being fetched this cycle |
| slot_nop | output | 1 | Instruction executing this cycle is squashed |
| lc_advance | output | 1 | One-cycle strobe after popping a flagged word |
| imem_wr_req | output | 1 | One-cycle instruction-memory write request |

## Verification
The bench builds the block with its default parameters: a 14-bit PC and a 5-bit stack pointer, which gives 32 entries. With only 32 entries, a run of 34 nested calls followed by 34 returns wraps the pointer twice and overwrites the two oldest entries. This checks the modulo-32 pointer arithmetic directly, and the bench confirms the exact popped addresses. Squashed slots, armed returns and cancelled returns are then mixed in a long randomized stream, which reaches the ST_KILL_PEND state and returns that fall across squashed instructions.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        XF_SEQ  = 2'b00,
        XF_JUMP = 2'b01,
        XF_DISP = 2'b10,
        XF_RSVD = 2'b11
    } xfer_e;

    typedef enum logic [2:0] {
        ACT_SEQ,
        ACT_JUMP,
        ACT_CALL,
        ACT_RET,
        ACT_IWR
    } act_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_KILL,
        ST_PEND,
        ST_KILL_PEND
    } seq_state_e;

endpackage

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
(
    input  logic [1:0] kind,
    input  logic       cond,
    input  logic       r,
    input  logic       p,
    input  logic       n,
    input  logic       killed,
    output act_e       act,
    output logic       taken,
    output logic       squash_req
);

    logic use_code;
    logic is_disp;

    always_comb begin
        is_disp  = (xfer_e'(kind) == XF_DISP);
        use_code = !killed && (is_disp || ((xfer_e'(kind) == XF_JUMP) && cond));
        act      = ACT_SEQ;
        if (use_code) begin
            unique case ({r, p})
                2'b00: act = ACT_JUMP;
                2'b01: act = ACT_CALL;
                2'b10: act = ACT_RET;
                2'b11: act = is_disp ? ACT_RET : ACT_IWR;
            endcase
        end
        taken      = (act == ACT_JUMP) || (act == ACT_CALL) || (act == ACT_RET);
        squash_req = taken && n;
    end

endmodule

// File: rtl/useq_retstack.sv
module useq_retstack #(
    parameter int AW = 5,
    parameter int DW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] ptr_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] ptr_inc;

    assign ptr_inc = ptr_q + AW'(1);
    assign rdata   = mem_q[ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_inc;
        end else if (pop) begin
            ptr_q <= ptr_q - AW'(1);
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[gi] <= '0;
            end else if (push && (ptr_inc == AW'(gi))) begin
                mem_q[gi] <= wdata;
            end
        end
    end

    AST_PUSH_PREINC: assert property (@(posedge clk) disable iff (rst)
        push |=> ptr_q == AW'($past(ptr_q) + AW'(1))); // R8
    AST_POP_POSTDEC: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> ptr_q == AW'($past(ptr_q) - AW'(1))); // R8
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(push && pop)); // R8

endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int PC_W   = 14,
    parameter int STK_AW = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      xfer_kind,
    input  logic            cond_met,
    input  logic            r_bit,
    input  logic            p_bit,
    input  logic            n_bit,
    input  logic            popj_next,
    input  logic [PC_W-1:0] target_addr,
    input  logic            ret_flag,
    output logic [PC_W-1:0] fetch_pc,
    output logic            slot_nop,
    output logic            lc_advance,
    output logic            imem_wr_req
);

    localparam int STK_DW = PC_W + 1;

    seq_state_e state_q, state_d;
    logic       killed, pending;

    act_e       dec_act, eff_act;
    logic       dec_taken, dec_sq, eff_sq, arm;

    logic [PC_W-1:0]   pc_q, pc_d, pc_inc, ret_addr;
    logic              lc_q, lc_d, iwr_q, iwr_d;
    logic              push_en, pop_en;
    logic [STK_DW-1:0] push_word, pop_word;

    assign killed  = (state_q == ST_KILL) || (state_q == ST_KILL_PEND);
    assign pending = (state_q == ST_PEND) || (state_q == ST_KILL_PEND);

    useq_decode u_dec (
        .kind       (xfer_kind),
        .cond       (cond_met),
        .r          (r_bit),
        .p          (p_bit),
        .n          (n_bit),
        .killed     (killed),
        .act        (dec_act),
        .taken      (dec_taken),
        .squash_req (dec_sq)
    );

    useq_retstack #(.AW(STK_AW), .DW(STK_DW)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push_en),
        .pop   (pop_en),
        .wdata (push_word),
        .rdata (pop_word)
    );

    // next-state and datapath selection
    always_comb begin
        if (pending && !dec_taken) begin
            eff_act = ACT_RET;
            eff_sq  = 1'b0;
        end else begin
            eff_act = dec_act;
            eff_sq  = dec_sq;
        end
        arm       = popj_next && !killed;
        pc_inc    = pc_q + PC_W'(1);
        ret_addr  = n_bit ? pc_q : pc_inc;
        push_word = {ret_flag, ret_addr};
        push_en   = (eff_act == ACT_CALL);
        pop_en    = (eff_act == ACT_RET);
        unique case (eff_act)
            ACT_JUMP, ACT_CALL: pc_d = target_addr;
            ACT_RET:            pc_d = pop_word[PC_W-1:0];
            default:            pc_d = pc_inc;
        endcase
        lc_d  = pop_en && pop_word[PC_W];
        iwr_d = (eff_act == ACT_IWR);
        unique case ({eff_sq, arm})
            2'b00: state_d = ST_RUN;
            2'b01: state_d = ST_PEND;
            2'b10: state_d = ST_KILL;
            2'b11: state_d = ST_KILL_PEND;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RUN;
        else     state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            lc_q  <= 1'b0;
            iwr_q <= 1'b0;
        end else begin
            pc_q  <= pc_d;
            lc_q  <= lc_d;
            iwr_q <= iwr_d;
        end
    end

    assign fetch_pc    = pc_q;
    assign slot_nop    = killed;
    assign lc_advance  = lc_q;
    assign imem_wr_req = iwr_q;

    AST_SQUASH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        dec_sq |=> slot_nop); // R7
    AST_KILLED_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        killed |-> !push_en); // R7
    AST_IWR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        imem_wr_req |-> fetch_pc == PC_W'($past(fetch_pc) + PC_W'(1))); // R6
    AST_LC_NEEDS_POP: assert property (@(posedge clk) disable iff (rst)
        lc_advance |-> $past(pop_en)); // R11
    AST_PEND_POPS: assert property (@(posedge clk) disable iff (rst)
        (pending && !dec_taken) |-> pop_en); // R9

endmodule

// File: tb/useq_nextaddr_test.sv
`timescale 1ns/1ps
module useq_nextaddr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  xfer_kind = 2'b00;
    logic        cond_met = 1'b0, r_bit = 1'b0, p_bit = 1'b0, n_bit = 1'b0;
    logic        popj_next = 1'b0, ret_flag = 1'b0;
    logic [13:0] target_addr = '0;
    logic [13:0] fetch_pc;
    logic        slot_nop, lc_advance, imem_wr_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    m_stack[32];
    int    m_ptr, m_pc;
    bit    m_pend, m_kill, m_lc, m_iwr;
    string m_tag;

    always #2.5 clk = ~clk;

    useq_nextaddr uut (
        .clk(clk), .rst(rst), .xfer_kind(xfer_kind), .cond_met(cond_met),
        .r_bit(r_bit), .p_bit(p_bit), .n_bit(n_bit), .popj_next(popj_next),
        .target_addr(target_addr), .ret_flag(ret_flag), .fetch_pc(fetch_pc),
        .slot_nop(slot_nop), .lc_advance(lc_advance), .imem_wr_req(imem_wr_req)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int act;
        bit taken, sq;
        int w;
        if (rst) begin
            foreach (m_stack[i]) m_stack[i] = 0;
            m_ptr = 0; m_pc = 0; m_pend = 0; m_kill = 0; m_lc = 0; m_iwr = 0;
            m_tag = "R1";
            return;
        end
        if (m_kill || xfer_kind == 2'b00 || xfer_kind == 2'b11 ||
            (xfer_kind == 2'b01 && !cond_met)) act = 0;
        else if (!r_bit && !p_bit) act = 1;
        else if (!r_bit && p_bit)  act = 2;
        else if (r_bit && !p_bit)  act = 3;
        else act = (xfer_kind == 2'b10) ? 3 : 4;
        taken = (act >= 1 && act <= 3);
        sq = taken && n_bit;
        case (act)
            0: m_tag = "R2";
            1: m_tag = "R3";
            2: m_tag = "R4 R8";
            3: m_tag = "R5 R8";
            default: m_tag = "R6";
        endcase
        if (m_kill) m_tag = "R7";
        if (m_pend && !taken) begin act = 3; sq = 0; m_tag = "R9"; end
        else if (m_pend) m_tag = "R10";
        m_lc = 0;
        m_iwr = (act == 4);
        case (act)
            1: m_pc = target_addr;
            2: begin
                w = n_bit ? m_pc : (m_pc + 1) % 16384;
                m_ptr = (m_ptr + 1) % 32;
                m_stack[m_ptr] = w + (ret_flag ? 16384 : 0);
                m_pc = target_addr;
            end
            3: begin
                w = m_stack[m_ptr];
                m_pc = w % 16384;
                m_lc = (w / 16384) % 2;
                m_ptr = (m_ptr + 31) % 32;
            end
            default: m_pc = (m_pc + 1) % 16384;
        endcase
        m_pend = popj_next && !m_kill;
        m_kill = sq;
    endtask

    task automatic compare();
        check(m_tag, fetch_pc, m_pc);
        check("R7", slot_nop, m_kill);
        check("R11", lc_advance, m_lc);
        check("R6", imem_wr_req, m_iwr);
    endtask

    task automatic cyc(int kind, bit c, bit r, bit p, bit n, bit pj, int tgt, bit fl);
        xfer_kind = 2'(kind); cond_met = c; r_bit = r; p_bit = p; n_bit = n;
        popj_next = pj; target_addr = 14'(tgt); ret_flag = fl;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) begin @(posedge clk); model_step(); @(negedge clk); end
        // R1 reset state
        check("R1", fetch_pc, 0); check("R1", slot_nop, 0);
        check("R1", lc_advance, 0); check("R1", imem_wr_req, 0);
        rst = 1'b0;
        // R2 sequential and unmet jump
        cyc(0, 0, 0, 0, 0, 0, 'h100, 0);
        cyc(1, 0, 0, 1, 1, 0, 'h200, 0);
        cyc(3, 1, 1, 1, 1, 0, 'h300, 0);
        // R3 jump, R4 call with and without squash
        cyc(1, 1, 0, 0, 0, 0, 'h0A0, 0);
        cyc(1, 1, 0, 1, 0, 0, 'h1B0, 1);
        cyc(2, 0, 0, 1, 1, 0, 'h2C0, 0);
        // R7 squashed slot ignores a call
        cyc(1, 1, 0, 1, 0, 1, 'h3D0, 1);
        // R5 pops, R11 flag
        cyc(1, 1, 1, 0, 0, 0, 'h000, 0);
        cyc(2, 0, 1, 1, 0, 0, 'h3FF, 0);
        // R6 instruction write request
        cyc(1, 1, 1, 1, 0, 0, 'h123, 0);
        cyc(1, 1, 1, 1, 1, 0, 'h123, 0);
        // R8 wrap: 34 nested calls, 34 returns
        for (int i = 0; i < 34; i++) cyc(2, 0, 0, 1, 0, 0, 'h400 + i * 8, i % 2);
        for (int i = 0; i < 34; i++) cyc(1, 1, 1, 0, 0, 0, 0, 0);
        // R9 armed return after a sequential step
        cyc(1, 1, 0, 1, 0, 0, 'h555, 1);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        // R10 armed return cancelled by a jump
        cyc(1, 1, 0, 1, 0, 0, 'h666, 0);
        cyc(0, 0, 0, 0, 0, 1, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 'h777, 0);
        // R9 over a squashed instruction
        cyc(1, 1, 0, 0, 1, 1, 'h088, 0);
        cyc(1, 1, 0, 0, 0, 0, 'h099, 0);
        // mixed stream
        for (int i = 0; i < 4000; i++) begin
            cyc($urandom_range(0, 3), 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom_range(0, 5) == 0), $urandom_range(0, 16383),
                1'($urandom));
        end
        done = 1;
        summary();
        $finish;
    end

endmodule